// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block is the power-state controller of a small microcontroller. It holds the current operating mode: active, standby, stop, watch or subactive. It moves between these modes on decoded STOP and standby instruction strobes, on a system reset event, on a wake pin, and on the timer and external interrupt requests. Three level control bits steer the choice: a watch-select bit, a stay-on-subclock bit and a direct-wake bit.

For each mode the block drives the main-oscillator enable, the subclock enable, the main-clock select, the CPU clock enable and the A/D enable. Whenever a mode change restarts the main oscillator, a loadable down-counter holds the CPU clock off for a programmable number of cycles. The clock is released when the counter reaches its terminal count.

The block also keeps the instruction-speed bit used in subactive mode. It produces an instruction tick at one of two rates, one twice the other. The whole block runs on one clock, which stands for the always-running subclock.

Top module: `pwr_mode_seq`

## Requirements
- R1: After `rst_n` is low at a clock edge, the mode is active with the clock released: `mode_o`=0 and `main_osc_en`, `sub_osc_en`, `cpu_clk_en` are all 1. `spd_sel` is 0 and `stab_busy` is 0.
- R2: In active mode with the clock released, `stop_instr` moves to watch when `watch_sel`=1 and to stop when it is 0. `standby_instr` moves to standby (main and subclock on, CPU clock off). In standby, `tmr_irq` or `ext_irq` returns to active with the clock released at once, with no wait.
- R3: Watch mode has the main oscillator off, the subclock on and the CPU clock off. A timer or external interrupt in watch mode goes to subactive when `stay_slow`=1. When `stay_slow`=0 it goes to active through the stabilization wait.
- R4: Subactive mode has the main oscillator off, the subclock on, the CPU clock on and `adc_en` off. In subactive, interrupts are ignored. A STOP or standby strobe goes to active through the wait when `direct_wake`=1 and `stay_slow`=0, and goes to watch otherwise.
- R5: Stop mode has both oscillators off and the CPU clock off. Interrupts are ignored in stop mode. `wake_pin` leaves stop for active through the stabilization wait.
- R6: A wake through the wait samples `stab_len` (L) at the event edge E. `cpu_clk_en`, `clk_sel_main` and `adc_en` are 0 after edges E through E+L, and all become 1 after edge E+L+1. `stab_busy` is high over the same span, and `stab_done` pulses in the cycle before release.
- R7: `sys_reset` takes priority over every other event in every mode, including a wait already running. It forces active mode and restarts the wait from `stab_len`.
- R8: While the wait runs, instruction strobes and interrupts are ignored. The release cycle does not move.
- R9: A write to `spd_sel` through `spd_wr`/`spd_data` takes effect only in active mode with the clock released; in any other case it is ignored. In subactive mode, `sub_tick` pulses once every 2 cycles when `spd_sel`=1 and once every 4 cycles when it is 0.
- R10: `mode_o` encodes active=0, standby=1, stop=2, watch=3, subactive=4, and takes no other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (subclock domain) |
| rst_n | input | 1 | Synchronous active-low block reset |
| sys_reset | input | 1 | System reset event, highest priority wake |
| wake_pin | input | 1 | External stop-cancel request |
| stop_instr | input | 1 | Decoded STOP instruction strobe |
| standby_instr | input | 1 | Decoded standby instruction strobe |
| tmr_irq | input | 1 | Timer interrupt request |
| ext_irq | input | 1 | External interrupt request |
| watch_sel | input | 1 | STOP in active goes to watch when 1 |
| stay_slow | input | 1 | Wake goes to subactive when 1 |
| direct_wake | input | 1 | Subactive STOP/standby jumps to active when 1 |
| spd_wr | input | 1 | Write strobe for the speed bit |
| spd_data | input | 1 | Speed bit write data |
| stab_len | input | STAB_W | Stabilization wait length |
| mode_o | output | 3 | Current mode code |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable |
| clk_sel_main | output | 1 | CPU clock taken from the main oscillator |
| cpu_clk_en | output | 1 | CPU clock running |
| adc_en | output | 1 | A/D converter enable |
| stab_busy | output | 1 | Stabilization wait in progress |
| stab_done | output | 1 | Terminal-count pulse of the wait |
| spd_sel | output | 1 | Subactive instruction speed bit |
| sub_tick | output | 1 | Subactive instruction tick |

## Verification
The mode and the enables follow registered state through combinational decode, so each of them is due right after the edge that samples the stimulus. The bench drives inputs at the falling edge and pushes the expected item at the same time. The monitor pops that item one nanosecond after the next rising edge. A wake through the wait is then checked item by item: L+1 items with the CPU clock held, followed by the release item, so that an early or late release by even one cycle mismatches. The tick rate is counted over eight consecutive cycles, a whole number of periods at both rates.

// File: rtl/pwr_mode_pkg.sv
// Shared types for the power-mode sequencer.
// Assumes the mode codes are visible at the top port, so they stay fixed.
package pwr_mode_pkg;

    typedef enum logic [2:0] {
        PM_ACTIVE  = 3'd0,
        PM_STANDBY = 3'd1,
        PM_STOP    = 3'd2,
        PM_WATCH   = 3'd3,
        PM_SUBACT  = 3'd4
    } pm_mode_e;

    typedef struct packed {
        logic main_osc;
        logic sub_osc;
        logic clk_main;
        logic cpu_run;
        logic adc_on;
    } pm_enables_t;

    // Enable pattern for a mode; hold=1 while the stabilization wait runs.
    function automatic pm_enables_t enables_for(input pm_mode_e m, input logic hold);
        pm_enables_t e;
        e = '0;
        case (m)
            PM_ACTIVE: begin
                e.main_osc = 1'b1;
                e.sub_osc  = 1'b1;
                e.clk_main = !hold;
                e.cpu_run  = !hold;
                e.adc_on   = !hold;
            end
            PM_STANDBY: begin
                e.main_osc = 1'b1;
                e.sub_osc  = 1'b1;
                e.clk_main = 1'b1;
            end
            PM_WATCH: begin
                e.sub_osc  = 1'b1;
            end
            PM_SUBACT: begin
                e.sub_osc  = 1'b1;
                e.cpu_run  = 1'b1;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pms_next_mode.sv
// Next-mode decision for the power-mode sequencer.
// Purely combinational. System reset wins over everything. While the
// stabilization wait runs in active mode, other events are ignored.
// load_wait requests a fresh load of the stabilization counter.
module pms_next_mode
    import pwr_mode_pkg::*;
(
    input  pm_mode_e cur_mode,
    input  logic     holding,
    input  logic     sys_reset,
    input  logic     wake_pin,
    input  logic     stop_instr,
    input  logic     standby_instr,
    input  logic     wake_irq,
    input  logic     watch_sel,
    input  logic     stay_slow,
    input  logic     direct_wake,
    output pm_mode_e nxt_mode,
    output logic     load_wait
);

    // Transition table with reset priority.
    always_comb begin
        nxt_mode  = cur_mode;
        load_wait = 1'b0;
        if (sys_reset) begin
            nxt_mode  = PM_ACTIVE;
            load_wait = 1'b1;
        end else begin
            case (cur_mode)
                PM_ACTIVE: begin
                    if (!holding) begin
                        if (stop_instr) begin
                            nxt_mode = watch_sel ? PM_WATCH : PM_STOP;
                        end else if (standby_instr) begin
                            nxt_mode = PM_STANDBY;
                        end
                    end
                end
                PM_STANDBY: begin
                    if (wake_irq) begin
                        nxt_mode = PM_ACTIVE;
                    end
                end
                PM_STOP: begin
                    if (wake_pin) begin
                        nxt_mode  = PM_ACTIVE;
                        load_wait = 1'b1;
                    end
                end
                PM_WATCH: begin
                    if (wake_irq) begin
                        if (stay_slow) begin
                            nxt_mode = PM_SUBACT;
                        end else begin
                            nxt_mode  = PM_ACTIVE;
                            load_wait = 1'b1;
                        end
                    end
                end
                PM_SUBACT: begin
                    if (stop_instr || standby_instr) begin
                        if (direct_wake && !stay_slow) begin
                            nxt_mode  = PM_ACTIVE;
                            load_wait = 1'b1;
                        end else begin
                            nxt_mode = PM_WATCH;
                        end
                    end
                end
                default: begin
                    nxt_mode  = PM_ACTIVE;
                    load_wait = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/pms_stab_counter.sv
// Oscillator-stabilization down-counter.
// load samples len and starts the wait. busy stays high until the
// count has passed zero. done pulses in the last busy cycle. A load
// while busy restarts the wait.
module pms_stab_counter #(
    parameter int STAB_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAB_W-1:0] len,
    output logic              busy,
    output logic              done
);

    logic [STAB_W-1:0] cnt_q;
    logic              busy_q;

    // Load, count down, and drop busy after the zero cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (load) begin
            cnt_q  <= len;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // Terminal-count pulse, suppressed by a restart.
    always_comb begin
        done = busy_q && (cnt_q == '0) && !load;
    end

    assign busy = busy_q;

endmodule

// File: rtl/pms_sub_divider.sv
// Subactive instruction tick generator.
// Counts only while run is high and restarts at zero otherwise.
// The tick period is FAST_DIV cycles when fast=1 and twice that when
// fast=0.
module pms_sub_divider #(
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int SLOW_DIV = 2 * FAST_DIV;
    localparam int CW       = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_DIV - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last;

    // Pick the wrap value from the speed bit.
    always_comb begin
        last = fast ? FAST_LAST : SLOW_LAST;
    end

    // Count while running, wrapping at the selected period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q <= '0;
        end else if (cnt_q >= last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // One tick per period.
    always_comb begin
        tick = run && (cnt_q == last);
    end

endmodule

// File: rtl/pwr_mode_seq.sv
// Power-mode sequencer top.
// Holds the current mode and the subactive speed bit. Decodes the
// clock and oscillator enables from them. Assumes all inputs are
// synchronous to clk and that instruction strobes last one cycle.
module pwr_mode_seq
    import pwr_mode_pkg::*;
#(
    parameter int STAB_W   = 8,
    parameter int FAST_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset,
    input  logic              wake_pin,
    input  logic              stop_instr,
    input  logic              standby_instr,
    input  logic              tmr_irq,
    input  logic              ext_irq,
    input  logic              watch_sel,
    input  logic              stay_slow,
    input  logic              direct_wake,
    input  logic              spd_wr,
    input  logic              spd_data,
    input  logic [STAB_W-1:0] stab_len,
    output logic [2:0]        mode_o,
    output logic              main_osc_en,
    output logic              sub_osc_en,
    output logic              clk_sel_main,
    output logic              cpu_clk_en,
    output logic              adc_en,
    output logic              stab_busy,
    output logic              stab_done,
    output logic              spd_sel,
    output logic              sub_tick
);

    pm_mode_e    mode_q;
    pm_mode_e    mode_d;
    logic        load_wait;
    logic        busy;
    logic        spd_q;
    logic        wake_irq;
    pm_enables_t en;

    // Either interrupt source can wake.
    always_comb begin
        wake_irq = tmr_irq | ext_irq;
    end

    pms_next_mode u_next (
        .cur_mode      (mode_q),
        .holding       (busy),
        .sys_reset     (sys_reset),
        .wake_pin      (wake_pin),
        .stop_instr    (stop_instr),
        .standby_instr (standby_instr),
        .wake_irq      (wake_irq),
        .watch_sel     (watch_sel),
        .stay_slow     (stay_slow),
        .direct_wake   (direct_wake),
        .nxt_mode      (mode_d),
        .load_wait     (load_wait)
    );

    pms_stab_counter #(.STAB_W(STAB_W)) u_stab (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load_wait),
        .len   (stab_len),
        .busy  (busy),
        .done  (stab_done)
    );

    pms_sub_divider #(.FAST_DIV(FAST_DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (mode_q == PM_SUBACT),
        .fast  (spd_q),
        .tick  (sub_tick)
    );

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= PM_ACTIVE;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Speed bit, writable only in active mode with the clock released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spd_q <= 1'b0;
        end else if (spd_wr && (mode_q == PM_ACTIVE) && !busy) begin
            spd_q <= spd_data;
        end
    end

    // Enable decode from the mode and the wait state.
    always_comb begin
        en = enables_for(mode_q, busy);
    end

    assign mode_o       = mode_q;
    assign main_osc_en  = en.main_osc;
    assign sub_osc_en   = en.sub_osc;
    assign clk_sel_main = en.clk_main;
    assign cpu_clk_en   = en.cpu_run;
    assign adc_en       = en.adc_on;
    assign stab_busy    = busy;
    assign spd_sel      = spd_q;

endmodule

// File: rtl/pwr_mode_seq_chk.sv
// Assertion checker for the power-mode sequencer, bound to the top.
// Observes ports only.
module pwr_mode_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sys_reset,
    input logic       stop_instr,
    input logic       tmr_irq,
    input logic       ext_irq,
    input logic       watch_sel,
    input logic       stay_slow,
    input logic [2:0] mode_o,
    input logic       main_osc_en,
    input logic       sub_osc_en,
    input logic       clk_sel_main,
    input logic       cpu_clk_en,
    input logic       adc_en,
    input logic       stab_busy,
    input logic       spd_sel
);

    // R2: STOP in released active mode picks watch or stop.
    a_r2_stop_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0 && !stab_busy && stop_instr && !sys_reset)
        |=> (mode_o == ($past(watch_sel) ? 3'd3 : 3'd2)));

    // R3: an interrupt in watch with stay_slow set enters subactive.
    a_r3_watch_to_sub: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3 && (tmr_irq || ext_irq) && stay_slow && !sys_reset)
        |=> (mode_o == 3'd4));

    // R4: subactive runs the CPU from the subclock with A/D off.
    a_r4_sub_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4) |-> (!main_osc_en && sub_osc_en && cpu_clk_en && !adc_en));

    // R6: the CPU clock stays held while the wait runs.
    a_r6_hold_clock: assert property (@(posedge clk) disable iff (!rst_n)
        stab_busy |-> (!cpu_clk_en && !clk_sel_main && !adc_en));

    // R6: the end of the wait releases the main clock.
    a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stab_busy) |-> (cpu_clk_en && clk_sel_main && mode_o == 3'd0));

    // R7: a system reset forces active mode with a fresh wait.
    a_r7_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> (mode_o == 3'd0 && stab_busy));

    // R9: the speed bit is frozen outside released active mode.
    a_r9_speed_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != 3'd0 || stab_busy) |=> $stable(spd_sel));

    // R10: only the five mode codes appear.
    a_r10_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

endmodule

bind pwr_mode_seq pwr_mode_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sys_reset    (sys_reset),
    .stop_instr   (stop_instr),
    .tmr_irq      (tmr_irq),
    .ext_irq      (ext_irq),
    .watch_sel    (watch_sel),
    .stay_slow    (stay_slow),
    .mode_o       (mode_o),
    .main_osc_en  (main_osc_en),
    .sub_osc_en   (sub_osc_en),
    .clk_sel_main (clk_sel_main),
    .cpu_clk_en   (cpu_clk_en),
    .adc_en       (adc_en),
    .stab_busy    (stab_busy),
    .spd_sel      (spd_sel)
);

// File: tb/tb_pwr_mode_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes the expected mode/enables for
// each cycle; the monitor pops and compares after the next rising edge.
module tb_pwr_mode_seq;

    localparam logic [2:0] M_ACT = 3'd0;
    localparam logic [2:0] M_SBY = 3'd1;
    localparam logic [2:0] M_STP = 3'd2;
    localparam logic [2:0] M_WCH = 3'd3;
    localparam logic [2:0] M_SUB = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_reset = 1'b0, wake_pin = 1'b0, stop_instr = 1'b0, standby_instr = 1'b0;
    logic       tmr_irq = 1'b0, ext_irq = 1'b0, watch_sel = 1'b0, stay_slow = 1'b0, direct_wake = 1'b0;
    logic       spd_wr = 1'b0, spd_data = 1'b0;
    logic [7:0] stab_len = 8'd3;
    logic [2:0] mode_o;
    logic       main_osc_en, sub_osc_en, clk_sel_main, cpu_clk_en, adc_en;
    logic       stab_busy, stab_done, spd_sel, sub_tick;

    int checks = 0;
    int errors = 0;

    typedef struct {
        string      tag;
        logic [2:0] mode;
        logic       mo;
        logic       so;
        logic       ce;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    pwr_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset), .wake_pin(wake_pin),
        .stop_instr(stop_instr), .standby_instr(standby_instr), .tmr_irq(tmr_irq),
        .ext_irq(ext_irq), .watch_sel(watch_sel), .stay_slow(stay_slow),
        .direct_wake(direct_wake), .spd_wr(spd_wr), .spd_data(spd_data),
        .stab_len(stab_len), .mode_o(mode_o), .main_osc_en(main_osc_en),
        .sub_osc_en(sub_osc_en), .clk_sel_main(clk_sel_main), .cpu_clk_en(cpu_clk_en),
        .adc_en(adc_en), .stab_busy(stab_busy), .stab_done(stab_done),
        .spd_sel(spd_sel), .sub_tick(sub_tick)
    );

    // Monitor: compare the oldest expectation one ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (mode_o !== e.mode || main_osc_en !== e.mo || sub_osc_en !== e.so ||
                cpu_clk_en !== e.ce) begin
                errors++;
                $display("FAIL %s: got mode=%0d main=%0b sub=%0b cpu=%0b exp mode=%0d main=%0b sub=%0b cpu=%0b",
                         e.tag, mode_o, main_osc_en, sub_osc_en, cpu_clk_en,
                         e.mode, e.mo, e.so, e.ce);
            end
        end
    end

    // Direct value check.
    task automatic chk(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s: got %0d exp %0d", tag, act, exp_v);
        end
    endtask

    // Driver: push the expectation for the coming edge, then clear strobes.
    task automatic go(input string tag, input logic [2:0] m, input logic mo,
                      input logic so, input logic ce);
        exp_t e;
        e.tag = tag; e.mode = m; e.mo = mo; e.so = so; e.ce = ce;
        sb.push_back(e);
        @(negedge clk);
        stop_instr = 1'b0; standby_instr = 1'b0; tmr_irq = 1'b0; ext_irq = 1'b0;
        sys_reset = 1'b0; wake_pin = 1'b0; spd_wr = 1'b0;
    endtask

    // Remaining wait cycles after the event item, then the release.
    task automatic stab_rest(input string tag, input int n);
        for (int i = 0; i < n; i++) go(tag, M_ACT, 1, 1, 0);
        go(tag, M_ACT, 1, 1, 1);
    endtask

    // Count subactive ticks over eight cycles.
    task automatic count_ticks(input string tag, input int exp_n);
        int t = 0;
        for (int i = 0; i < 8; i++) begin
            go(tag, M_SUB, 0, 1, 1);
            t += int'(sub_tick);
        end
        chk(tag, t, exp_n);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R10 active code 0
        go("R1 R10 reset state", M_ACT, 1, 1, 1);
        chk("R1 spd_sel after reset", spd_sel, 0);
        chk("R1 stab_busy after reset", stab_busy, 0);
        chk("R1 adc_en after reset", adc_en, 1);
        // R9 write accepted in released active
        spd_wr = 1; spd_data = 1;
        go("R9 write in active", M_ACT, 1, 1, 1);
        chk("R9 spd_sel written", spd_sel, 1);
        // R2 standby and wake without wait
        standby_instr = 1;
        go("R2 enter standby", M_SBY, 1, 1, 0);
        tmr_irq = 1;
        go("R2 standby wake", M_ACT, 1, 1, 1);
        // R2 STOP with watch_sel=0, R5 stop behaviour
        watch_sel = 0; stop_instr = 1;
        go("R2 enter stop", M_STP, 0, 0, 0);
        ext_irq = 1;
        go("R5 irq ignored in stop", M_STP, 0, 0, 0);
        wake_pin = 1;
        go("R5 wake pin", M_ACT, 1, 1, 0);
        stab_rest("R6 wait L=3", 3);
        // R2 STOP with watch_sel=1, R3 watch to subactive
        watch_sel = 1; stop_instr = 1;
        go("R2 enter watch", M_WCH, 0, 1, 0);
        stay_slow = 1; ext_irq = 1;
        go("R3 watch to subactive", M_SUB, 0, 1, 1);
        chk("R4 adc off in subactive", adc_en, 0);
        spd_wr = 1; spd_data = 0;
        go("R9 write in subactive", M_SUB, 0, 1, 1);
        chk("R9 spd_sel locked", spd_sel, 1);
        tmr_irq = 1;
        go("R4 irq ignored in subactive", M_SUB, 0, 1, 1);
        count_ticks("R9 fast tick count", 4);
        // R4 standby strobe to watch, R3 wake to active, R8 ignore during wait
        direct_wake = 0; standby_instr = 1;
        go("R4 subactive to watch", M_WCH, 0, 1, 0);
        stay_slow = 0; tmr_irq = 1;
        go("R3 watch to active", M_ACT, 1, 1, 0);
        stop_instr = 1;
        go("R8 stop ignored in wait", M_ACT, 1, 1, 0);
        stab_rest("R6 R8 release on time", 2);
        // R4 direct wake
        watch_sel = 1; stop_instr = 1;
        go("R2 enter watch again", M_WCH, 0, 1, 0);
        stay_slow = 1; tmr_irq = 1;
        go("R3 watch to subactive again", M_SUB, 0, 1, 1);
        stay_slow = 0; direct_wake = 1; stop_instr = 1;
        go("R4 direct to active", M_ACT, 1, 1, 0);
        stab_rest("R4 direct wait", 3);
        // R7 reset beats STOP, then reloads a running wait
        direct_wake = 0; stop_instr = 1; sys_reset = 1;
        go("R7 reset beats stop", M_ACT, 1, 1, 0);
        go("R7 wait", M_ACT, 1, 1, 0);
        go("R7 wait", M_ACT, 1, 1, 0);
        sys_reset = 1;
        go("R7 reload", M_ACT, 1, 1, 0);
        stab_rest("R7 reloaded wait", 3);
        // R9 slow rate
        spd_wr = 1; spd_data = 0;
        go("R9 clear speed bit", M_ACT, 1, 1, 1);
        chk("R9 spd_sel cleared", spd_sel, 0);
        watch_sel = 1; stop_instr = 1;
        go("R2 watch for slow", M_WCH, 0, 1, 0);
        stay_slow = 1; ext_irq = 1;
        go("R3 subactive for slow", M_SUB, 0, 1, 1);
        count_ticks("R9 slow tick count", 2);
        sys_reset = 1;
        go("R7 reset in subactive", M_ACT, 1, 1, 0);
        stab_rest("R7 wait from subactive", 3);
        // R6 zero-length wait
        stab_len = 8'd0; watch_sel = 0; stop_instr = 1;
        go("R2 stop for zero wait", M_STP, 0, 0, 0);
        wake_pin = 1;
        go("R6 zero wait hold", M_ACT, 1, 1, 0);
        go("R6 zero wait release", M_ACT, 1, 1, 1);
        @(negedge clk);
        finish_run();
    end

endmodule